// File: doc/BRIEF.md
# Multi-Mode Pin Interface Unit

This unit sits between one small real-time core and its general-purpose pins. The pins can be run in four modes. In the first, pins behave as plain registers. In the second, a strobe pin latches the other inputs. In the third, one input pin is sampled serially into a 28-bit register at a programmable rate. In the fourth, a 32-bit word is sent out serially on a single output pin. The core selects the mode and the rate divisor through two configuration inputs. It reaches the unit's registers through a simple port with a write strobe, a write address, write data, a read address and combinational read data.

All input pins pass through a two-stage synchronizer. Edge detection, serial sampling and the plain read path all use the synchronized copy. The rate divisor N gives one sample or shift step every N+1 clocks.

Top module: `egpio`

## Requirements
- R1: After reset, the output pins are all zero, and reads of addresses 1, 2 and 3 return zero.
- R2: A read of address 0 returns the input pins, zero-extended. This value reflects pin changes two clocks after they occur, and no event latches it.
- R3: In mode 0 (plain), a write to address 0 sets the output pins from the low write-data bits on the next clock edge.
- R4: In modes 1 (strobe capture) and 2 (serial in), the unit treats the pins as input-only and drives every output pin to zero.
- R5: In mode 1, a rising edge on the top input pin (bit 16) latches input bits 15:0 into the capture register and sets the valid flag. A read of address 1 returns the data in bits 15:0 and the valid flag in bit 31.
- R6: The capture register keeps its value while the strobe stays high, when it falls, and when data pins change. Strobe edges are ignored in any mode other than 1.
- R7: A write to address 1 clears the valid flag and leaves the captured data unchanged.
- R8: In mode 2, input pin 0 is shifted into the LSB of a 28-bit register, with older bits moving toward the MSB. One sample is taken every N+1 clocks, and the first sample comes N+1 clocks after the unit enters the mode. A read of address 2 returns the register in bits 27:0.
- R9: Once more than 28 samples have been taken, the serial-in register holds the newest 28, and older bits are dropped.
- R10: In mode 3 (serial out), a write to address 3 loads a 32-bit word. The word is driven MSB first on output pin 0, starting the clock after the write, with each bit held for N+1 clocks. All other output pins stay zero.
- R11: In mode 3, output pin 0 is low whenever no word is being sent. A read of address 3 returns a busy flag in bit 0 that stays high only while bits remain to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Mode: 0 plain, 1 strobe capture, 2 serial in, 3 serial out |
| div_cfg | input | 16 | Rate divisor N; one step every N+1 clocks |
| pins_in | input | 17 | Input pins; bit 16 is the strobe, bit 0 is the serial data pin |
| pins_out | output | 16 | Output pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |

## Verification
The hardest case to reach from the ports is filling the serial-in register past its 28-bit depth with a known bit order. The sampling phase depends on the synchronizer delay and on the cycle in which the mode changes. The bench sets the divisor to zero and drives a new bit on pin 0 every clock. It enters mode 2 exactly two clocks after the first bit and leaves after 40 samples. This makes the bit that is kept in each position computable from the stimulus alone. A second run with a divisor of 3 holds pin 0 high and checks the register between sample points to pin down the rate.

// File: rtl/egpio.sv
module egpio #(
  parameter int IN_W  = 17,
  parameter int OUT_W = 16,
  parameter int DIV_W = 16,
  parameter int SI_W  = 28,
  parameter int SO_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [IN_W-1:0]  pins_in,
  output logic [OUT_W-1:0] pins_out,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data
);
  localparam int CAP_W = IN_W - 1;
  localparam int SO_CW = $clog2(SO_W + 1);

  logic [IN_W-1:0]  s1, s2;
  logic             strb_d;
  logic [CAP_W-1:0] cap;
  logic             cap_v;
  logic [DIV_W-1:0] cnt;
  logic [SI_W-1:0]  si;
  logic [SO_W-1:0]  so;
  logic [SO_CW-1:0] so_cnt;
  logic [OUT_W-1:0] out_r;

  wire shifting = mode[1];
  wire tick     = shifting && (cnt >= div_cfg);
  wire cap_ev   = (mode == 2'd1) && s2[IN_W-1] && !strb_d;
  wire so_load  = wr_en && (wr_addr == 2'd3);
  wire so_busy  = (so_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; strb_d <= 1'b0;
      cap <= '0; cap_v <= 1'b0; cnt <= '0; si <= '0;
      so <= '0; so_cnt <= '0; out_r <= '0;
    end else begin
      s1 <= pins_in;
      s2 <= s1;
      strb_d <= s2[IN_W-1];
      if (!shifting || tick || so_load) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (cap_ev) begin
        cap   <= s2[CAP_W-1:0];
        cap_v <= 1'b1;
      end else if (wr_en && wr_addr == 2'd1) cap_v <= 1'b0;
      if (mode == 2'd2 && tick) si <= {si[SI_W-2:0], s2[0]};
      if (wr_en && wr_addr == 2'd0) out_r <= wr_data[OUT_W-1:0];
      if (so_load) begin
        so     <= wr_data[SO_W-1:0];
        so_cnt <= SO_CW'(SO_W);
      end else if (mode == 2'd3 && tick && so_busy) begin
        so     <= so << 1;
        so_cnt <= so_cnt - 1'b1;
      end
    end
  end

  always_comb begin
    pins_out = '0;
    case (mode)
      2'd0:    pins_out = out_r;
      2'd3:    pins_out[0] = so_busy && so[SO_W-1];
      default: pins_out = '0;
    endcase
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = 32'(s2);
      2'd1:    rd_data = {cap_v, {(31-CAP_W){1'b0}}, cap};
      2'd2:    rd_data = 32'(si);
      default: rd_data = {31'b0, so_busy};
    endcase
  end

  p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ev |=> $stable(cap));
  p_cap_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> cap_v);
  p_si_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(si));
  p_so_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && tick && so_busy && !so_load) |=> so_cnt == $past(so_cnt) - 1'b1);
  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !so_busy) |-> pins_out == '0);
  p_in_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd2) |-> pins_out == '0);
endmodule

// File: tb/egpio_bench.sv
module egpio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] div_cfg = 16'd0;
  logic [16:0] pins_in = '0;
  logic [15:0] pins_out;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  egpio u_egpio (.clk(clk), .rst_n(rst_n), .mode(mode), .div_cfg(div_cfg),
    .pins_in(pins_in), .pins_out(pins_out), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; mode = 2'd0; pins_in = '0;
    wait_n(2); rst_n = 1'b1; wait_n(1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_reset();
    check("R1 pins_out", 32'(pins_out), 32'h0);
    rd(2'd1, v); check("R1 capture", v, 32'h0);
    rd(2'd2, v); check("R1 shift-in", v, 32'h0);
    rd(2'd3, v); check("R1 busy", v, 32'h0);
  endtask

  task automatic t_direct;
    logic [31:0] v;
    mode = 2'd0;
    pins_in = 17'h1A5A5;
    wait_n(1); rd(2'd0, v); check("R2 not yet", v, 32'h0);
    wait_n(1); rd(2'd0, v); check("R2 read", v, 32'h1A5A5);
    pins_in = 17'h00F0F; wait_n(2); rd(2'd0, v); check("R2 follow", v, 32'h00F0F);
    wr(2'd0, 32'h0000BEEF);
    check("R3 drive", 32'(pins_out), 32'h0000BEEF);
    mode = 2'd1; #1; check("R4 mode1", 32'(pins_out), 32'h0);
    mode = 2'd2; #1; check("R4 mode2", 32'(pins_out), 32'h0);
    mode = 2'd0; #1; check("R3 restore", 32'(pins_out), 32'h0000BEEF);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    do_reset();
    mode = 2'd1; pins_in = {1'b0, 16'h1234}; wait_n(3);
    pins_in = {1'b1, 16'h1234}; wait_n(3);
    rd(2'd1, v); check("R5 capture", v, 32'h80001234);
    pins_in = {1'b1, 16'h5678}; wait_n(4);
    rd(2'd1, v); check("R6 hold high", v, 32'h80001234);
    pins_in = {1'b0, 16'h5678}; wait_n(4);
    rd(2'd1, v); check("R6 hold fall", v, 32'h80001234);
    wr(2'd1, 32'h0);
    rd(2'd1, v); check("R7 clear", v, 32'h00001234);
    pins_in = {1'b1, 16'h9ABC}; wait_n(3);
    rd(2'd1, v); check("R5 second", v, 32'h80009ABC);
    mode = 2'd0; pins_in = {1'b0, 16'h1111}; wait_n(3);
    pins_in = {1'b1, 16'h1111}; wait_n(4);
    rd(2'd1, v); check("R6 other mode", v, 32'h80009ABC);
  endtask

  task automatic t_shift_rate;
    logic [31:0] v;
    do_reset();
    div_cfg = 16'd3; pins_in = 17'h1; wait_n(3);
    mode = 2'd2;
    wait_n(3);  rd(2'd2, v); check("R8 before first", v, 32'h0);
    wait_n(1);  rd(2'd2, v); check("R8 first", v, 32'h1);
    wait_n(3);  rd(2'd2, v); check("R8 between", v, 32'h1);
    wait_n(1);  rd(2'd2, v); check("R8 second", v, 32'h3);
    wait_n(3);  rd(2'd2, v); check("R8 between2", v, 32'h3);
    wait_n(1);  rd(2'd2, v); check("R8 third", v, 32'h7);
    mode = 2'd0;
  endtask

  task automatic t_shift_stream;
    logic [63:0] pat;
    logic [27:0] exp;
    logic [31:0] v;
    pat = 64'hD5A317C90E6BF248;
    exp = '0;
    do_reset();
    div_cfg = 16'd0;
    for (int i = 0; i <= 42; i++) begin
      pins_in[0] = pat[i % 64];
      if (i == 2) mode = 2'd2;
      if (i == 42) mode = 2'd0;
      @(negedge clk);
    end
    for (int j = 0; j < 40; j++) exp = {exp[26:0], pat[j]};
    wait_n(2);
    rd(2'd2, v); check("R9 newest 28 kept", v, 32'(exp));
  endtask

  task automatic t_shift_out;
    logic [31:0] v;
    logic [31:0] word;
    word = 32'hA5C30F96;
    do_reset();
    div_cfg = 16'd2; mode = 2'd3; wait_n(4);
    check("R11 idle low", 32'(pins_out), 32'h0);
    rd(2'd3, v); check("R11 idle busy", v, 32'h0);
    wr(2'd3, word);
    rd(2'd3, v); check("R11 busy", v, 32'h1);
    for (int k = 0; k < 32; k++) begin
      check("R10 serial bit", 32'(pins_out), {31'b0, word[31-k]});
      wait_n(3);
    end
    check("R11 low after", 32'(pins_out), 32'h0);
    rd(2'd3, v); check("R11 done", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_capture();
    t_shift_rate();
    t_shift_stream();
    t_shift_out();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule